// File: doc/BRIEF.md
# Serial Framed Packet Receiver

This block sits on one bit-serial output port of a packet switch and turns its traffic back into bytes. The port carries a single data line and two active-low strobes: a frame strobe that stays low for the whole packet, and a valid strobe that marks the cycles whose data bit is real. The receiver takes a bit only when both strobes are low in the same rising-edge sample. Accepted bits are collected least significant bit first, and every eighth bit produces a byte on a parallel output with a one-cycle valid pulse.

Packets have no length field. The receiver treats the first cycle in which the frame strobe is sampled high after being low as the end of the packet. In the cycle after that sample it raises an end-of-packet pulse together with the number of whole bytes in the packet. It flags two framing faults: a packet that ends with leftover bits, and a valid strobe asserted while no frame is open. The receiver cannot stall, because the port has no buffering behind it, so every bit is handled in the cycle it arrives.

Top module: `serial_pkt_rx`

## Requirements
- R1: While `rst_n` is low, and in the first output cycle after it, `byte_data`, `byte_valid`, `pkt_end`, `pkt_len`, `err_partial` and `err_stray` are all zero. Any partly built byte and the byte count are cleared.
- R2: `ser_in` is accepted only when `frame_n` and `valid_n` are both sampled low at the same rising edge. If `valid_n` is high while the frame is open, the bit is skipped and the partial byte stays as it was.
- R3: Accepted bits fill a byte from bit 0 upward. The first accepted bit of a packet becomes bit 0 of the first byte. After the eighth accepted bit, `byte_data` shows the byte and `byte_valid` is high for exactly the next cycle. `byte_data` then holds its value until the next byte.
- R4: `pkt_end` is high for one cycle. It follows the first rising edge at which `frame_n` is sampled high after it was sampled low. It is never high together with `byte_valid`.
- R5: With `pkt_end`, `pkt_len` shows the number of complete bytes in the packet that just ended. It holds that value until the next packet ends.
- R6: `err_partial` is high together with `pkt_end` when the packet ended with 1 to 7 leftover accepted bits. Those bits are dropped, and the next packet starts at bit 0 of a fresh byte.
- R7: `err_stray` is high for one cycle after any rising edge at which `valid_n` is low while `frame_n` is high.
- R8: Bits sampled while `frame_n` is high do not change any byte of a later packet.
- R9: The byte count saturates at 2^LEN_W-1. A longer packet reports that value.
- R10: A frame that opens and closes with no accepted bit gives `pkt_end` with `pkt_len` equal to 0 and no `err_partial`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data bit |
| frame_n | input | 1 | Active-low frame strobe, low for the whole packet |
| valid_n | input | 1 | Active-low strobe marking a real data bit |
| byte_data | output | BYTE_W | Last assembled byte |
| byte_valid | output | 1 | One-cycle pulse for a new byte |
| pkt_end | output | 1 | One-cycle end-of-packet pulse |
| pkt_len | output | LEN_W | Whole bytes in the last packet |
| err_partial | output | 1 | Packet ended with leftover bits |
| err_stray | output | 1 | Valid strobe seen with no open frame |

## Verification
The assertions check a set of pulse rules on every cycle. A byte pulse must follow a sample with both strobes low. An end pulse must follow a sample with the frame high, and it never coincides with a byte pulse. A partial-byte error only appears alongside an end pulse, and a stray-valid error must follow a frame-high, valid-low sample. Properties of this kind cannot show bit order, byte counts, count saturation, or whether leftover or stray bits leak into a later packet. Only the bench scenarios can show those: packets with valid gaps, a truncated packet, stray bits between packets, back-to-back frames, an empty frame and an overlong frame, each compared against a queue-based model.

// File: rtl/serial_pkt_rx_pkg.sv
package serial_pkt_rx_pkg;

    // Framing fault flags reported with a packet boundary or a stray strobe.
    typedef struct packed {
        logic partial;
        logic stray;
    } rx_fault_t;

    // Sampled strobe decode used by the frame tracker.
    typedef struct packed {
        logic take;
        logic close;
    } rx_strobe_t;

endpackage

// File: rtl/rx_deser.sv
// Bit-to-byte assembler: fills from bit 0 upward, emits one byte per BYTE_W accepted bits.
module rx_deser #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              bit_in,
    input  logic              flush,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld,
    output logic              byte_done,
    output logic              pending
);
    localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] shf;
        logic [CW-1:0]     cnt;
        logic [BYTE_W-1:0] dat;
        logic              vld;
    } dsr_t;

    dsr_t st_d, st_q;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        st_d    = st_q;
        st_d.vld = 1'b0;
        shifted = {bit_in, st_q.shf[BYTE_W-1:1]};
        if (flush) begin
            st_d.shf = '0;
            st_d.cnt = '0;
        end else if (take) begin
            if (st_q.cnt == LAST) begin
                st_d.dat = shifted;
                st_d.vld = 1'b1;
                st_d.shf = '0;
                st_d.cnt = '0;
            end else begin
                st_d.shf = shifted;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_out  = st_q.dat;
    assign byte_vld  = st_q.vld;
    assign byte_done = take && (st_q.cnt == LAST);
    assign pending   = (st_q.cnt != '0);
endmodule

// File: rtl/rx_frame_track.sv
// Frame state, byte counting, end-of-packet and fault reporting.
module rx_frame_track
    import serial_pkt_rx_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             valid_n,
    input  logic             byte_done,
    input  logic             pending,
    output rx_strobe_t       strobe,
    output logic             pkt_end,
    output logic [LEN_W-1:0] pkt_len,
    output rx_fault_t        fault
);
    localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

    typedef struct packed {
        logic             open;
        logic [LEN_W-1:0] cnt;
        logic             eop;
        logic [LEN_W-1:0] len;
        rx_fault_t        flt;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        strobe.take  = !frame_n && !valid_n;
        strobe.close = frame_n && st_q.open;
    end

    always_comb begin
        st_d     = st_q;
        st_d.eop = 1'b0;
        st_d.flt = '0;
        st_d.open = !frame_n;
        if (!frame_n) begin
            if (byte_done && (st_q.cnt != CNT_MAX))
                st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            if (st_q.open) begin
                st_d.eop         = 1'b1;
                st_d.len         = st_q.cnt;
                st_d.flt.partial = pending;
                st_d.cnt         = '0;
            end
            if (!valid_n)
                st_d.flt.stray = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pkt_end = st_q.eop;
    assign pkt_len = st_q.len;
    assign fault   = st_q.flt;
endmodule

// File: rtl/serial_pkt_rx.sv
module serial_pkt_rx
    import serial_pkt_rx_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              frame_n,
    input  logic              valid_n,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    output logic              pkt_end,
    output logic [LEN_W-1:0]  pkt_len,
    output logic              err_partial,
    output logic              err_stray
);
    rx_strobe_t strobe;
    rx_fault_t  fault;
    logic       byte_done;
    logic       pending;

    rx_frame_track #(.LEN_W(LEN_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .valid_n   (valid_n),
        .byte_done (byte_done),
        .pending   (pending),
        .strobe    (strobe),
        .pkt_end   (pkt_end),
        .pkt_len   (pkt_len),
        .fault     (fault)
    );

    rx_deser #(.BYTE_W(BYTE_W)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (strobe.take),
        .bit_in    (ser_in),
        .flush     (strobe.close),
        .byte_out  (byte_data),
        .byte_vld  (byte_valid),
        .byte_done (byte_done),
        .pending   (pending)
    );

    assign err_partial = fault.partial;
    assign err_stray   = fault.stray;
endmodule

// File: rtl/serial_pkt_rx_checker.sv
module serial_pkt_rx_checker (
    input logic clk,
    input logic rst_n,
    input logic frame_n,
    input logic valid_n,
    input logic byte_valid,
    input logic pkt_end,
    input logic err_partial,
    input logic err_stray
);
    AST_BYTE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (!$past(frame_n) && !$past(valid_n))); // R2
    AST_BYTE_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid); // R3
    AST_END_AFTER_FRAME_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> $past(frame_n)); // R4
    AST_END_NOT_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_end && byte_valid)); // R4
    AST_PARTIAL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        err_partial |-> pkt_end); // R6
    AST_STRAY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        err_stray |-> ($past(frame_n) && !$past(valid_n))); // R7
endmodule

bind serial_pkt_rx serial_pkt_rx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_n     (frame_n),
    .valid_n     (valid_n),
    .byte_valid  (byte_valid),
    .pkt_end     (pkt_end),
    .err_partial (err_partial),
    .err_stray   (err_stray)
);

// File: tb/serial_pkt_rx_bench.sv
`timescale 1ns/1ps
module serial_pkt_rx_bench;
    localparam int BYTE_W = 8;
    localparam int LEN_W  = 8;
    localparam int LEN_MAX = (1 << LEN_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0;
    logic frame_n = 1'b1;
    logic valid_n = 1'b1;
    logic [BYTE_W-1:0] byte_data;
    logic byte_valid, pkt_end, err_partial, err_stray;
    logic [LEN_W-1:0] pkt_len;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    serial_pkt_rx #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_serial_pkt_rx (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .frame_n(frame_n),
        .valid_n(valid_n), .byte_data(byte_data), .byte_valid(byte_valid),
        .pkt_end(pkt_end), .pkt_len(pkt_len), .err_partial(err_partial),
        .err_stray(err_stray)
    );

    // Behavioural reference state
    bit bitq[$];
    int m_bytes = 0;
    bit m_open = 1'b0;
    int e_byte = 0, e_len = 0;
    bit e_bv = 0, e_eop = 0, e_ep = 0, e_es = 0;

    task automatic check(input string tag, input int got, input int exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, got, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            bitq.delete();
            m_bytes = 0; m_open = 0;
            e_byte = 0; e_len = 0; e_bv = 0; e_eop = 0; e_ep = 0; e_es = 0;
        end else begin
            e_bv = 0; e_eop = 0; e_ep = 0; e_es = 0;
            if (!frame_n) begin
                m_open = 1;
                if (!valid_n) begin
                    bitq.push_back(ser_in);
                    if (bitq.size() == BYTE_W) begin
                        e_byte = 0;
                        for (int i = 0; i < BYTE_W; i++) e_byte += int'(bitq[i]) << i;
                        bitq.delete();
                        e_bv = 1;
                        if (m_bytes < LEN_MAX) m_bytes++;
                    end
                end
            end else begin
                if (m_open) begin
                    e_eop = 1;
                    e_len = m_bytes;
                    e_ep = (bitq.size() != 0);
                    bitq.delete();
                    m_bytes = 0;
                    m_open = 0;
                end
                if (!valid_n) e_es = 1;
            end
        end
        #2;
        if (!done) begin
            check("R3 byte_data", int'(byte_data), e_byte);
            check("R3 byte_valid", int'(byte_valid), int'(e_bv));
            check("R4 pkt_end", int'(pkt_end), int'(e_eop));
            check("R5 pkt_len", int'(pkt_len), e_len);
            check("R6 err_partial", int'(err_partial), int'(e_ep));
            check("R7 err_stray", int'(err_stray), int'(e_es));
        end
    end

    task automatic put(input logic f, input logic v, input logic b);
        @(negedge clk);
        frame_n = f; valid_n = v; ser_in = b;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit gaps);
        for (int i = 0; i < 8; i++) begin
            put(1'b0, 1'b0, b[i]);
            if (gaps && (i % 3 == 1)) put(1'b0, 1'b1, ~b[i]); // R2 skipped bit
        end
    endtask

    task automatic close_frame();
        put(1'b1, 1'b1, 1'b0);
        put(1'b1, 1'b1, 1'b0);
        put(1'b1, 1'b1, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        mismatched++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 byte_data", int'(byte_data), 0);
        check("R1 byte_valid", int'(byte_valid), 0);
        check("R1 pkt_end", int'(pkt_end), 0);
        check("R1 pkt_len", int'(pkt_len), 0);
        check("R1 errors", int'(err_partial) + int'(err_stray), 0);
        rst_n = 1'b1;
        put(1'b1, 1'b1, 1'b0);

        // Three bytes, continuous
        send_byte(8'hA5, 0); send_byte(8'h3C, 0); send_byte(8'h01, 0);
        close_frame();
        check("R5 len3", int'(pkt_len), 3);

        // Two bytes with valid gaps
        send_byte(8'h96, 1); send_byte(8'h7E, 1);
        close_frame();
        check("R2 gapped byte", int'(byte_data), 8'h7E);

        // Truncated: one byte plus 5 bits
        send_byte(8'hC3, 0);
        for (int i = 0; i < 5; i++) put(1'b0, 1'b0, 1'b1);
        close_frame();
        // R6 next packet aligned
        send_byte(8'h12, 0);
        close_frame();
        check("R6 realigned byte", int'(byte_data), 8'h12);

        // R8 stray bits between packets
        for (int i = 0; i < 6; i++) put(1'b1, 1'b0, 1'b1);
        put(1'b1, 1'b1, 1'b0);
        send_byte(8'h40, 0);
        close_frame();
        check("R8 byte after stray", int'(byte_data), 8'h40);

        // Back-to-back frames, one high cycle between
        send_byte(8'hF0, 0);
        put(1'b1, 1'b1, 1'b0);
        send_byte(8'h0F, 1);
        close_frame();
        check("R4 back-to-back", int'(pkt_len), 1);

        // R10 empty frame
        for (int i = 0; i < 4; i++) put(1'b0, 1'b1, 1'b1);
        close_frame();
        check("R10 empty len", int'(pkt_len), 0);

        // R9 saturation
        for (int k = 0; k < LEN_MAX + 5; k++) send_byte(8'(k), 0);
        close_frame();
        check("R9 saturated len", int'(pkt_len), LEN_MAX);

        // Reset mid-packet then fresh packet
        send_byte(8'hAA, 0);
        for (int i = 0; i < 3; i++) put(1'b0, 1'b0, 1'b1);
        @(negedge clk); rst_n = 1'b0; frame_n = 1'b1; valid_n = 1'b1;
        @(negedge clk);
        check("R1 mid reset len", int'(pkt_len), 0);
        rst_n = 1'b1;
        put(1'b1, 1'b1, 1'b0);
        send_byte(8'h5A, 0);
        close_frame();
        check("R1 post reset byte", int'(byte_data), 8'h5A);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule